// File: doc/BRIEF.md
# PWM Fault Trip Controller

This block sits between a bank of PWM generator outputs and the pad cells that drive a power stage. An active-low fault line from an external sensor (overcurrent, overvoltage, overtemperature) takes every PWM pad out of drive through a purely combinational path. That path works with no clock running and while reset is applied. The same fault, once synchronized, clears a sticky output-enable bit and raises a sticky fault flag that drives an interrupt line.

Software reaches the block through a small register port. It can read and write the output-enable bit, which is the only way to re-arm the pads, and writing it to zero is a second way into the safe state. It can choose falling-edge or level-sensitive flag generation, mask the interrupt line, and read and clear the fault flag. The pads are driven as a data value plus a per-channel output enable, and the pad cell turns a low enable into high impedance.

Top module: `pwm_fault_trip`

## Requirements
- R1: When `fault_n` is held low, the output-enable bit (register 0, bit 0) reads 0 no later than three clock edges after the pin fell.
- R2: While the output-enable bit is 0, every bit of `pad_oe` is 0. While it is 1 and `fault_n` is high, every bit of `pad_oe` is 1 and `pad_out` equals `pwm_in`.
- R3: Releasing `fault_n` leaves the output-enable bit at 0. Only a write of 1 to register 0 bit 0 sets it back to 1.
- R4: A software write of 0 to register 0 bit 0 clears the output-enable bit and drives all of `pad_oe` low, with no fault present.
- R5: `pad_oe` goes to all zeros as soon as `fault_n` goes low, before any clock edge, and this also holds while `rst_n` is low.
- R6: In level mode (register 0 bit 1 = 0), a fault held low sets the fault flag (register 1 bit 0) again after every clear, so the flag still reads 1 one cycle after a clear.
- R7: In edge mode (register 0 bit 1 = 1), the flag is set only by a falling edge of the synchronized fault. A fault held low raises it once, and after a clear it stays 0.
- R8: After reset the output-enable bit is 0, level mode is selected, the interrupt enable (register 0 bit 2) is 1, the flag is 0 and `irq` is 0.
- R9: The fault flag stays 1 until a write to register 1 with bit 0 set. Writing 0 to that bit leaves it unchanged.
- R10: If `fault_n` is low when reset is released, the next genuine falling edge after the pin returns high still sets the flag in edge mode.
- R11: A write of 1 to the output-enable bit while the synchronized fault is low is ignored, and the bit stays 0.
- R12: `irq` equals the fault flag while the interrupt enable is 1. With the enable at 0, `irq` is 0 and the flag is still set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and synchronizer clock |
| rst_n | input | 1 | Synchronous active-low reset |
| fault_n | input | 1 | Asynchronous active-low fault line |
| pwm_in | input | NUM_CH | PWM levels from the generators |
| pad_out | output | NUM_CH | Data to the pad cells |
| pad_oe | output | NUM_CH | Pad drive enables, 0 = high impedance |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address: 0 control, 1 flag |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address: 0 control, 1 flag |
| rd_data | output | DATA_W | Combinational read data |
| irq | output | 1 | Fault interrupt request |

## Verification
The bench drops the fault line midway between clock edges and samples `pad_oe` before the next edge. A design that waits for a clock or for reset release to trip the pads fails there. It tries to re-arm while the fault is still low and then releases the fault with no write. A design that re-enables on release, or that accepts the early write, shows active pad enables at that point. It compares level and edge mode by clearing the flag under a held fault, which catches a flag whose clear wins over a fresh set and an edge detector that fires more than once. It also enters reset with the pin low and then gives one clean falling edge. A detector whose history starts at a fixed value either fires on reset exit or misses that edge.

// File: rtl/pft_pkg.sv
// Package pft_pkg
// Register addresses and bit positions shared by the fault trip logic
// and its bench. Assumes a two-register map with 2-bit addresses.
package pft_pkg;
    localparam int ADDR_W   = 2;
    localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
    localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
    localparam int B_OE     = 0;   // control: output enable
    localparam int B_EDGE   = 1;   // control: 1 = edge mode, 0 = level mode
    localparam int B_IRQEN  = 2;   // control: interrupt enable
    localparam int B_FLAG   = 0;   // flag register: fault flag, write 1 clears
endpackage

// File: rtl/pft_sync.sv
// Module pft_sync
// Multi-stage synchronizer for the asynchronous fault line. The stages have
// no reset on purpose: they keep sampling the pin during reset, so the
// synchronized level is valid when reset is released.
// Assumes rst_n is held low for at least STAGES clock cycles.
module pft_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic async_in,
    output logic sync_out
);
    logic [STAGES-1:0] chain;

    // Shift the raw pin level through the synchronizer stages.
    always_ff @(posedge clk) begin
        chain <= {chain[STAGES-2:0], async_in};
    end

    assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/pft_detect.sv
// Module pft_detect
// Turns the synchronized active-low fault level into two events: a level
// event (fault present) and a falling-edge event. The history register
// tracks the synchronized level in every cycle, including reset, so it is
// loaded with the real pin level when reset is released and no false edge
// is seen for a pin that was already low.
module pft_detect (
    input  logic clk,
    input  logic fault_s_n,
    output logic lvl_evt,
    output logic fall_evt
);
    logic hist_n;

    // Keep last cycle's synchronized level; not reset, to avoid a false edge.
    always_ff @(posedge clk) begin
        hist_n <= fault_s_n;
    end

    // Level event while the fault is present, edge event on high-to-low.
    always_comb begin
        lvl_evt  = ~fault_s_n;
        fall_evt = hist_n & ~fault_s_n;
    end
endmodule

// File: rtl/pft_regs.sv
// Module pft_regs
// Software-visible state: the sticky output-enable bit, the mode and
// interrupt-enable bits, and the sticky fault flag, with a combinational
// read mux. A present fault wins over a software re-arm. A new flag event
// wins over a clear in the same cycle.
module pft_regs
    import pft_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_s_n,
    input  logic              lvl_evt,
    input  logic              fall_evt,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              out_en,
    output logic              irq
);
    logic edge_md;
    logic irq_en;
    logic flag;
    logic ctrl_wr;
    logic flag_clr;
    logic set_evt;

    // Decode writes and choose which event feeds the flag.
    always_comb begin
        ctrl_wr  = wr_en && (wr_addr == A_CTRL);
        flag_clr = wr_en && (wr_addr == A_FLAG) && wr_data[B_FLAG];
        set_evt  = edge_md ? fall_evt : lvl_evt;
    end

    // Output enable: a fault clears it, software may set or clear it otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n)
            out_en <= 1'b0;
        else if (!fault_s_n)
            out_en <= 1'b0;
        else if (ctrl_wr)
            out_en <= wr_data[B_OE];
    end

    // Mode and interrupt-enable bits; the interrupt is enabled out of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            edge_md <= 1'b0;
            irq_en  <= 1'b1;
        end else if (ctrl_wr) begin
            edge_md <= wr_data[B_EDGE];
            irq_en  <= wr_data[B_IRQEN];
        end
    end

    // Sticky fault flag: set by the selected event, cleared by writing one.
    always_ff @(posedge clk) begin
        if (!rst_n)
            flag <= 1'b0;
        else if (set_evt)
            flag <= 1'b1;
        else if (flag_clr)
            flag <= 1'b0;
    end

    // Read mux and interrupt output.
    always_comb begin
        rd_data = '0;
        if (rd_addr == A_CTRL) begin
            rd_data[B_OE]    = out_en;
            rd_data[B_EDGE]  = edge_md;
            rd_data[B_IRQEN] = irq_en;
        end else if (rd_addr == A_FLAG) begin
            rd_data[B_FLAG]  = flag;
        end
        irq = flag & irq_en;
    end

    // R1
    fault_clears_oe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !fault_s_n |=> !out_en);

    // R3
    oe_rise_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(out_en) |-> $past(wr_en && wr_addr == A_CTRL && wr_data[B_OE]));

    // R11
    rearm_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!fault_s_n && !out_en) |=> !out_en);

    // R6
    level_reassert_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!edge_md && lvl_evt) |=> flag);

    // R7
    edge_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (edge_md && $rose(flag)) |-> $past(fall_evt));

    // R9
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (flag && !flag_clr) |=> flag);
endmodule

// File: rtl/pwm_fault_trip.sv
// Module pwm_fault_trip
// Top level of the PWM fault trip controller. The raw fault pin gates the
// pad enables combinationally, so the pads leave drive without a clock and
// during reset. The synchronized fault feeds the sticky register logic.
// Assumes fault_n is active low and that the pad cell turns a low enable
// into high impedance.
module pwm_fault_trip
    import pft_pkg::*;
#(
    parameter int NUM_CH      = 6,
    parameter int DATA_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              fault_n,
    input  logic [NUM_CH-1:0] pwm_in,
    output logic [NUM_CH-1:0] pad_out,
    output logic [NUM_CH-1:0] pad_oe,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq
);
    logic fault_s_n;
    logic lvl_evt;
    logic fall_evt;
    logic out_en;

    pft_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk      (clk),
        .async_in (fault_n),
        .sync_out (fault_s_n)
    );

    pft_detect u_detect (
        .clk       (clk),
        .fault_s_n (fault_s_n),
        .lvl_evt   (lvl_evt),
        .fall_evt  (fall_evt)
    );

    pft_regs #(.DATA_W(DATA_W)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .fault_s_n (fault_s_n),
        .lvl_evt   (lvl_evt),
        .fall_evt  (fall_evt),
        .wr_en     (wr_en),
        .wr_addr   (wr_addr),
        .wr_data   (wr_data),
        .rd_addr   (rd_addr),
        .rd_data   (rd_data),
        .out_en    (out_en),
        .irq       (irq)
    );

    // Per-channel pad gating: the raw pin and the enable bit, no clock involved.
    for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_pad
        assign pad_out[ch] = pwm_in[ch];
        assign pad_oe[ch]  = out_en & fault_n;
    end

    // R2
    oe_follows_bit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !out_en |-> (pad_oe == '0));
endmodule

// File: tb/tb_pwm_fault_trip.sv
// Directed bench for pwm_fault_trip: one task per scenario, each checks itself.
module tb_pwm_fault_trip;
    import pft_pkg::*;

    localparam int CLK_P  = 10;
    localparam int NUM_CH = 6;
    localparam int DATA_W = 8;
    localparam logic [NUM_CH-1:0] ALL_ON = '1;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              fault_n = 1'b1;
    logic [NUM_CH-1:0] pwm_in = '0;
    logic [NUM_CH-1:0] pad_out;
    logic [NUM_CH-1:0] pad_oe;
    logic              wr_en = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [DATA_W-1:0] wr_data = '0;
    logic [ADDR_W-1:0] rd_addr = '0;
    logic [DATA_W-1:0] rd_data;
    logic              irq;

    int total = 0;
    int bad   = 0;

    pwm_fault_trip #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) dut (
        .clk(clk), .rst_n(rst_n), .fault_n(fault_n), .pwm_in(pwm_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .wr_en(wr_en), .wr_addr(wr_addr),
        .wr_data(wr_data), .rd_addr(rd_addr), .rd_data(rd_data), .irq(irq)
    );

    always #(CLK_P/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [ADDR_W-1:0] a, input logic [DATA_W-1:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_data = '0;
    endtask

    task automatic rd(input logic [ADDR_W-1:0] a, output logic [DATA_W-1:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        tick(4);
        rst_n = 1'b1;
        tick(1);
    endtask

    // Control word helper: oe, edge, irq enable.
    function automatic logic [DATA_W-1:0] ctl(input logic oe, input logic edg, input logic ien);
        logic [DATA_W-1:0] v;
        v = '0;
        v[B_OE] = oe; v[B_EDGE] = edg; v[B_IRQEN] = ien;
        return v;
    endfunction

    task automatic t_reset_state();
        logic [DATA_W-1:0] d;
        do_reset();
        rd(A_CTRL, d);
        check("R8 ctrl after reset", d, ctl(1'b0, 1'b0, 1'b1));
        rd(A_FLAG, d);
        check("R8 flag after reset", d[B_FLAG], 0);
        check("R8 irq after reset", irq, 0);
        check("R2 pads off after reset", pad_oe, 0);
    endtask

    task automatic t_enable_pass();
        wr(A_CTRL, ctl(1'b1, 1'b0, 1'b1));
        pwm_in = 6'b101100;
        #1;
        check("R2 pad_oe when enabled", pad_oe, ALL_ON);
        check("R2 pad_out pattern a", pad_out, 6'b101100);
        pwm_in = 6'b010011;
        #1;
        check("R2 pad_out pattern b", pad_out, 6'b010011);
    endtask

    task automatic t_fault_trip();
        logic [DATA_W-1:0] d;
        @(negedge clk);
        #2 fault_n = 1'b0;
        #1;
        check("R5 pads off before any edge", pad_oe, 0);
        tick(4);
        rd(A_CTRL, d);
        check("R1 oe bit cleared by fault", d[B_OE], 0);
        rd(A_FLAG, d);
        check("R6 level fault sets flag", d[B_FLAG], 1);
        check("R12 irq follows flag", irq, 1);
        fault_n = 1'b1;
        tick(4);
        rd(A_CTRL, d);
        check("R3 release does not re-arm bit", d[B_OE], 0);
        check("R3 release does not re-arm pads", pad_oe, 0);
        wr(A_FLAG, 8'h01);
        wr(A_CTRL, ctl(1'b1, 1'b0, 1'b1));
        check("R3 write re-arms pads", pad_oe, ALL_ON);
    endtask

    task automatic t_sw_off();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b0, 1'b0, 1'b1));
        rd(A_CTRL, d);
        check("R4 software clear of oe", d[B_OE], 0);
        check("R4 software clear drops pads", pad_oe, 0);
        rd(A_FLAG, d);
        check("R4 no flag from software off", d[B_FLAG], 0);
    endtask

    task automatic t_level_repeat();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b0, 1'b0, 1'b1));
        fault_n = 1'b0;
        tick(4);
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, d);
        check("R6 level flag re-raised after clear", d[B_FLAG], 1);
        wr(A_FLAG, 8'h01);
        tick(1);
        rd(A_FLAG, d);
        check("R6 level flag re-raised second clear", d[B_FLAG], 1);
        fault_n = 1'b1;
        tick(4);
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, d);
        check("R6 flag clears once fault gone", d[B_FLAG], 0);
    endtask

    task automatic t_edge_single();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b0, 1'b1, 1'b1));
        fault_n = 1'b0;
        tick(4);
        rd(A_FLAG, d);
        check("R7 edge sets flag", d[B_FLAG], 1);
        wr(A_FLAG, 8'h01);
        tick(6);
        rd(A_FLAG, d);
        check("R7 held fault no second flag", d[B_FLAG], 0);
        check("R7 irq low while held", irq, 0);
        fault_n = 1'b1;
        tick(4);
        fault_n = 1'b0;
        tick(4);
        rd(A_FLAG, d);
        check("R7 new edge sets flag again", d[B_FLAG], 1);
        fault_n = 1'b1;
        tick(4);
    endtask

    task automatic t_sticky();
        logic [DATA_W-1:0] d;
        wr(A_FLAG, 8'h00);
        tick(3);
        rd(A_FLAG, d);
        check("R9 write of 0 leaves flag", d[B_FLAG], 1);
        wr(A_FLAG, 8'h01);
        rd(A_FLAG, d);
        check("R9 write of 1 clears flag", d[B_FLAG], 0);
    endtask

    task automatic t_rearm_blocked();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b1, 1'b1, 1'b1));
        fault_n = 1'b0;
        tick(4);
        wr(A_CTRL, ctl(1'b1, 1'b1, 1'b1));
        tick(1);
        rd(A_CTRL, d);
        check("R11 write 1 ignored under fault", d[B_OE], 0);
        check("R11 pads stay off", pad_oe, 0);
        fault_n = 1'b1;
        tick(4);
        rd(A_CTRL, d);
        check("R11 bit still 0 after release", d[B_OE], 0);
        wr(A_FLAG, 8'h01);
    endtask

    task automatic t_irq_mask();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b0, 1'b1, 1'b0));
        fault_n = 1'b0;
        tick(4);
        rd(A_FLAG, d);
        check("R12 flag set while masked", d[B_FLAG], 1);
        check("R12 irq masked", irq, 0);
        wr(A_CTRL, ctl(1'b0, 1'b1, 1'b1));
        check("R12 irq after unmask", irq, 1);
        fault_n = 1'b1;
        tick(4);
        wr(A_FLAG, 8'h01);
    endtask

    task automatic t_reset_low();
        logic [DATA_W-1:0] d;
        wr(A_CTRL, ctl(1'b1, 1'b0, 1'b1));
        @(negedge clk);
        rst_n = 1'b0;
        #2 fault_n = 1'b0;
        #1;
        check("R5 pads off during reset", pad_oe, 0);
        tick(4);
        rst_n = 1'b1;
        tick(1);
        wr(A_CTRL, ctl(1'b0, 1'b1, 1'b1));
        wr(A_FLAG, 8'h01);
        tick(4);
        rd(A_FLAG, d);
        check("R10 no false edge after reset", d[B_FLAG], 0);
        fault_n = 1'b1;
        tick(4);
        fault_n = 1'b0;
        tick(4);
        rd(A_FLAG, d);
        check("R10 first real edge detected", d[B_FLAG], 1);
        fault_n = 1'b1;
        tick(4);
    endtask

    initial begin : watchdog
        #(CLK_P * 200000);
        bad++;
        total++;
        $display("FAIL watchdog: actual=expired expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        t_reset_state();
        t_enable_pass();
        t_fault_trip();
        t_sw_off();
        t_level_repeat();
        t_edge_single();
        t_sticky();
        t_rearm_blocked();
        t_irq_mask();
        t_reset_low();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule